// File: doc/BRIEF.md
# Instruction and Unified TLB Victim Selector

This block picks the next entry to overwrite in two fully associative translation buffers. It owns a 32-bit MMU control word. For the small instruction TLB (four entries), the word holds a six-bit pairwise age matrix. Every hit or refill of an instruction-TLB entry makes that entry the most recent one. The field decodes continuously to the least recently used entry, and that entry is the refill victim. A matrix that cannot describe any ordering raises an error flag and falls back to entry 0.

For the unified TLB (64 entries), the word holds a six-bit replace counter and a six-bit boundary that software sets. The counter moves forward once per tick and wraps back to zero. A software load-TLB command writes the unified-TLB slot named by the counter's present value. The block drives that write strobe and index. The TLB arrays and their tag compare sit outside the block.

Software writes the whole control word through one write port. A write takes priority over any hardware update in the same cycle. Bits of the word that belong to none of the three fields are simply held.

Top module: `tlb_repl_ctrl`

## Requirements
- R1: After reset, ctl_q is 0x00000000, itlb_victim is 3 and itlb_lru_err is 0.
- R2: A cycle with cfg_wr_en high loads cfg_wr_data into ctl_q by the next cycle, discarding any access update or counter tick in that same cycle.
- R3: Age bits are ctl_q[31:26]. Each bit belongs to one pair of entries: bit 31 to pair (0,1), 30 to (0,2), 29 to (0,3), 28 to (1,2), 27 to (1,3) and 26 to (2,3). A set bit means the lower-numbered entry of the pair is older. An access to entry k with itlb_acc_vld high first clears every bit of a pair that contains k. It then sets the bits of the pairs (i,k) with i<k. Afterwards k is not the victim, unless the resulting field is illegal.
- R4: itlb_victim is 0 when (ctl_q & 0xE0000000)==0xE0000000. Otherwise it is 1 when (ctl_q & 0x98000000)==0x18000000. Otherwise it is 2 when (ctl_q & 0x54000000)==0x04000000. Otherwise it is 3 when (ctl_q & 0x2C000000)==0. At most one of these four patterns holds at a time.
- R5: When none of the four patterns holds, itlb_lru_err is 1 and itlb_victim is 0. Otherwise itlb_lru_err is 0.
- R6: The replace counter is ctl_q[15:10] and the boundary is ctl_q[23:18]. On a cycle with urc_tick high, the counter becomes its value plus one. If the boundary is nonzero and that new value exceeds the boundary, the counter becomes 0 instead. This also applies when the old value already exceeded the boundary.
- R7: With a boundary of 0, the counter runs through 63 and then wraps to 0.
- R8: utlb_wr_en follows ldtlb_req in the same cycle. utlb_wr_idx equals the counter value at that time, before any tick in that cycle takes effect.
- R9: The boundary field and all bits outside the three fields change only on a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Software write of the whole control word |
| cfg_wr_data | input | 32 | Value for the control word |
| ctl_q | output | 32 | Current control word |
| itlb_acc_vld | input | 1 | Instruction-TLB entry hit or refilled this cycle |
| itlb_acc_idx | input | 2 | Entry touched by that access |
| itlb_victim | output | 2 | Least recently used instruction-TLB entry |
| itlb_lru_err | output | 1 | Age field holds no legal ordering |
| urc_tick | input | 1 | Advance the unified-TLB replace counter |
| ldtlb_req | input | 1 | Software load-TLB command |
| utlb_wr_en | output | 1 | Unified-TLB entry write strobe |
| utlb_wr_idx | output | 6 | Unified-TLB entry to write |

## Verification
Directed access orders, such as all four entries touched in sequence or one entry touched repeatedly, show whether the update gives the wanted age order. A hand-built cyclic age field separates the error fallback from a normal decode. The counter runs under a small boundary, under a zero boundary across 63, and from a start value already above the boundary. These runs tell the boundary wrap apart from the full-range wrap. Random writes, accesses, ticks and load commands, many of them in the same cycle, expose wrong write priority and any leak into the held bits.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;

   // Ordinal of pair (a,b), a<b, in lexicographic order among n entries.
   function automatic int pair_ord(input int a, input int b, input int n);
      int o;
      int hit;
      o   = 0;
      hit = 0;
      for (int i = 0; i < n; i++) begin
         for (int j = i + 1; j < n; j++) begin
            if (i == a && j == b) hit = o;
            o++;
         end
      end
      return hit;
   endfunction

   // Bit position inside the age field; the first pair takes the top bit.
   function automatic int pair_bit(input int a, input int b, input int n);
      int w;
      w = n * (n - 1) / 2;
      if (a < b) return w - 1 - pair_ord(a, b, n);
      else       return w - 1 - pair_ord(b, a, n);
   endfunction

   // Every pair bit that involves entry k.
   function automatic logic [63:0] pairs_of(input int k, input int n);
      logic [63:0] m;
      m = '0;
      for (int j = 0; j < n; j++)
         if (j != k) m[pair_bit(k, j, n)] = 1'b1;
      return m;
   endfunction

   // Value the pair bits of k take when k is the oldest entry.
   function automatic logic [63:0] oldest_val(input int k, input int n);
      logic [63:0] m;
      m = '0;
      for (int j = k + 1; j < n; j++) m[pair_bit(k, j, n)] = 1'b1;
      return m;
   endfunction

   // Bits set when k becomes the newest entry.
   function automatic logic [63:0] newest_set(input int k, input int n);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < k; i++) m[pair_bit(i, k, n)] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] field_mask(input int lsb, input int w);
      logic [63:0] m;
      m = '0;
      for (int b = 0; b < w; b++) m[lsb + b] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/tlbr_lru_state.sv
module tlbr_lru_state import tlbr_pkg::*; #(
   parameter int N  = 4,
   parameter int W  = N * (N - 1) / 2,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [W-1:0]  ld_val,
   input  logic          acc_vld,
   input  logic [IW-1:0] acc_idx,
   output logic [W-1:0]  lru_q
);

   logic [W-1:0] clr_tab [N];
   logic [W-1:0] set_tab [N];
   logic [W-1:0] lru_d;
   logic         idx_ok;

   for (genvar k = 0; k < N; k++) begin : g_tab
      assign clr_tab[k] = W'(pairs_of(k, N));
      assign set_tab[k] = W'(newest_set(k, N));
   end

   assign idx_ok = (int'(acc_idx) < N);

   always_comb begin
      lru_d = lru_q;
      if (ld_en)
         lru_d = ld_val;
      else if (acc_vld && idx_ok)
         lru_d = (lru_q & ~clr_tab[acc_idx]) | set_tab[acc_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lru_q <= '0;
      else        lru_q <= lru_d;
   end

   assert_lru_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !acc_vld) |=> $stable(lru_q));

endmodule

// File: rtl/tlbr_lru_decode.sv
module tlbr_lru_decode import tlbr_pkg::*; #(
   parameter int N            = 4,
   parameter int W            = N * (N - 1) / 2,
   parameter int IW           = 2,
   parameter int ILLEGAL_PICK = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  lru,
   output logic [IW-1:0] victim,
   output logic          illegal
);

   logic [N-1:0] match;

   for (genvar k = 0; k < N; k++) begin : g_match
      localparam logic [W-1:0] CARE = W'(pairs_of(k, N));
      localparam logic [W-1:0] VAL  = W'(oldest_val(k, N));
      assign match[k] = ((lru & CARE) == VAL);
   end

   always_comb begin
      victim = IW'(ILLEGAL_PICK);
      for (int k = N - 1; k >= 0; k--)
         if (match[k]) victim = IW'(k);
   end

   assign illegal = ~|match;

   assert_single_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   assert_illegal_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (victim == IW'(ILLEGAL_PICK)));

endmodule

// File: rtl/tlbr_urc_state.sv
module tlbr_urc_state #(
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [IW-1:0] ld_urc,
   input  logic [IW-1:0] ld_urb,
   input  logic          tick,
   output logic [IW-1:0] urc_q,
   output logic [IW-1:0] urb_q
);

   localparam logic [IW-1:0] TOP = {IW{1'b1}};

   logic [IW:0]   inc;
   logic          wrap;
   logic [IW-1:0] urc_d;

   assign inc  = {1'b0, urc_q} + {{IW{1'b0}}, 1'b1};
   assign wrap = inc[IW] || ((urb_q != '0) && (inc[IW-1:0] > urb_q));

   always_comb begin
      urc_d = urc_q;
      if (ld_en)     urc_d = ld_urc;
      else if (tick) urc_d = wrap ? '0 : inc[IW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         urc_q <= '0;
         urb_q <= '0;
      end else begin
         urc_q <= urc_d;
         if (ld_en) urb_q <= ld_urb;
      end
   end

   assert_urc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld_en) |=> ((urc_q == '0) || ({1'b0, urc_q} == {1'b0, $past(urc_q)} + 1'b1)));

   assert_urc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld_en && urb_q != '0 && urc_q <= urb_q) |=> (urc_q <= urb_q));

   assert_full_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld_en && urb_q == '0 && urc_q == TOP) |=> (urc_q == '0));

   assert_urb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(urb_q));

endmodule

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl import tlbr_pkg::*; #(
   parameter int REG_W        = 32,
   parameter int ITLB_N       = 4,
   parameter int UTLB_IW      = 6,
   parameter int LRU_MSB      = 31,
   parameter int URB_LSB      = 18,
   parameter int URC_LSB      = 10,
   parameter int ILLEGAL_PICK = 0,
   localparam int IIW         = (ITLB_N > 1) ? $clog2(ITLB_N) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [REG_W-1:0]   cfg_wr_data,
   output logic [REG_W-1:0]   ctl_q,
   input  logic               itlb_acc_vld,
   input  logic [IIW-1:0]     itlb_acc_idx,
   output logic [IIW-1:0]     itlb_victim,
   output logic               itlb_lru_err,
   input  logic               urc_tick,
   input  logic               ldtlb_req,
   output logic               utlb_wr_en,
   output logic [UTLB_IW-1:0] utlb_wr_idx
);

   localparam int LRU_W   = ITLB_N * (ITLB_N - 1) / 2;
   localparam int LRU_LSB = LRU_MSB - LRU_W + 1;
   localparam logic [REG_W-1:0] LRU_M = REG_W'(field_mask(LRU_LSB, LRU_W));
   localparam logic [REG_W-1:0] URB_M = REG_W'(field_mask(URB_LSB, UTLB_IW));
   localparam logic [REG_W-1:0] URC_M = REG_W'(field_mask(URC_LSB, UTLB_IW));
   localparam logic [REG_W-1:0] KEEP  = ~(LRU_M | URB_M | URC_M);

   // Elaboration-time parameter checks
   if (REG_W > 64) begin : g_bad_regw
      $error("REG_W must not exceed 64");
   end
   if (ITLB_N < 2 || ITLB_N > 11) begin : g_bad_n
      $error("ITLB_N must be within 2..11");
   end
   if (LRU_LSB < 0 || LRU_MSB >= REG_W) begin : g_bad_lru
      $error("age field does not fit in the control word");
   end
   if (URB_LSB + UTLB_IW > REG_W || URC_LSB + UTLB_IW > REG_W) begin : g_bad_cnt
      $error("counter fields do not fit in the control word");
   end
   if (((LRU_M & URB_M) | (LRU_M & URC_M) | (URB_M & URC_M)) != '0) begin : g_bad_overlap
      $error("control word fields overlap");
   end
   if (ILLEGAL_PICK < 0 || ILLEGAL_PICK >= ITLB_N) begin : g_bad_pick
      $error("ILLEGAL_PICK must name an entry");
   end

   logic [LRU_W-1:0]   lru_q;
   logic [UTLB_IW-1:0] urc_q;
   logic [UTLB_IW-1:0] urb_q;
   logic [REG_W-1:0]   misc_q;

   tlbr_lru_state #(.N(ITLB_N), .W(LRU_W), .IW(IIW)) u_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (cfg_wr_en),
      .ld_val  (cfg_wr_data[LRU_MSB -: LRU_W]),
      .acc_vld (itlb_acc_vld),
      .acc_idx (itlb_acc_idx),
      .lru_q   (lru_q)
   );

   tlbr_lru_decode #(.N(ITLB_N), .W(LRU_W), .IW(IIW), .ILLEGAL_PICK(ILLEGAL_PICK)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .lru     (lru_q),
      .victim  (itlb_victim),
      .illegal (itlb_lru_err)
   );

   tlbr_urc_state #(.IW(UTLB_IW)) u_urc (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (cfg_wr_en),
      .ld_urc (cfg_wr_data[URC_LSB +: UTLB_IW]),
      .ld_urb (cfg_wr_data[URB_LSB +: UTLB_IW]),
      .tick   (urc_tick),
      .urc_q  (urc_q),
      .urb_q  (urb_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         misc_q <= '0;
      else if (cfg_wr_en) misc_q <= cfg_wr_data;
   end

   always_comb begin
      ctl_q                          = misc_q & KEEP;
      ctl_q[LRU_MSB -: LRU_W]        = lru_q;
      ctl_q[URB_LSB +: UTLB_IW]      = urb_q;
      ctl_q[URC_LSB +: UTLB_IW]      = urc_q;
   end

   assign utlb_wr_en  = ldtlb_req;
   assign utlb_wr_idx = urc_q;

   assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |=> (ctl_q == $past(cfg_wr_data)));

   assert_acc_not_victim_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (itlb_acc_vld && !cfg_wr_en) |=> (itlb_lru_err || itlb_victim != $past(itlb_acc_idx)));

   assert_misc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_en |=> ((ctl_q & KEEP) == $past(ctl_q & KEEP)));

endmodule

// File: tb/tb_tlb_repl_ctrl.sv
`timescale 1ns/100ps
module tb_tlb_repl_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [31:0] cfg_wr_data;
   logic [31:0] ctl_q;
   logic        itlb_acc_vld;
   logic [1:0]  itlb_acc_idx;
   logic [1:0]  itlb_victim;
   logic        itlb_lru_err;
   logic        urc_tick;
   logic        ldtlb_req;
   logic        utlb_wr_en;
   logic [5:0]  utlb_wr_idx;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] mdl;

   always #2.5 clk = ~clk;

   tlb_repl_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .ctl_q(ctl_q), .itlb_acc_vld(itlb_acc_vld), .itlb_acc_idx(itlb_acc_idx),
      .itlb_victim(itlb_victim), .itlb_lru_err(itlb_lru_err), .urc_tick(urc_tick),
      .ldtlb_req(ldtlb_req), .utlb_wr_en(utlb_wr_en), .utlb_wr_idx(utlb_wr_idx)
   );

   function automatic logic [2:0] exp_pick(input logic [31:0] r);
      if ((r & 32'hE000_0000) == 32'hE000_0000) return 3'b000;
      if ((r & 32'h9800_0000) == 32'h1800_0000) return 3'b001;
      if ((r & 32'h5400_0000) == 32'h0400_0000) return 3'b010;
      if ((r & 32'h2C00_0000) == 32'h0000_0000) return 3'b011;
      return 3'b100;
   endfunction

   function automatic logic [31:0] exp_access(input logic [31:0] r, input logic [1:0] k);
      case (k)
         2'd0:    return r & ~32'hE000_0000;
         2'd1:    return (r & ~32'h9800_0000) | 32'h8000_0000;
         2'd2:    return (r & ~32'h5400_0000) | 32'h5000_0000;
         default: return (r & ~32'h2C00_0000) | 32'h2C00_0000;
      endcase
   endfunction

   function automatic logic [31:0] exp_tick(input logic [31:0] r);
      int c, b, nx;
      c  = int'(r[15:10]);
      b  = int'(r[23:18]);
      nx = c + 1;
      if ((b != 0 && nx > b) || nx > 63) nx = 0;
      return {r[31:16], 6'(nx), r[9:0]};
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [31:0] d, input logic acc,
                       input logic [1:0] k, input logic tk, input logic ld, input string tag);
      logic [2:0] p;
      @(negedge clk);
      cfg_wr_en = wr; cfg_wr_data = d; itlb_acc_vld = acc; itlb_acc_idx = k;
      urc_tick = tk; ldtlb_req = ld;
      #0.5;
      check(ctl_q == mdl, tag, ctl_q, mdl);
      p = exp_pick(mdl);
      check(itlb_victim == p[1:0], "R4 victim", 32'(itlb_victim), 32'(p[1:0]));
      check(itlb_lru_err == p[2], "R5 error flag", 32'(itlb_lru_err), 32'(p[2]));
      check(utlb_wr_en == ld && utlb_wr_idx == mdl[15:10], "R8 load index",
            {25'd0, utlb_wr_en, utlb_wr_idx}, {25'd0, ld, mdl[15:10]});
      if (wr) mdl = d;
      else begin
         if (acc) mdl = exp_access(mdl, k);
         if (tk)  mdl = exp_tick(mdl);
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; cfg_wr_en = 0; cfg_wr_data = '0; itlb_acc_vld = 0;
      itlb_acc_idx = '0; urc_tick = 0; ldtlb_req = 0;
      mdl = '0;
      repeat (3) @(negedge clk);
      #0.5;
      check(ctl_q == 32'h0, "R1 reset word", ctl_q, 32'h0);
      check(itlb_victim == 2'd3 && !itlb_lru_err, "R1 reset victim",
            {29'd0, itlb_lru_err, itlb_victim}, 32'd3);
      rst_n = 1'b1;

      // R3: touch entries 0..3 in order; entry 0 becomes oldest again
      for (int k = 0; k < 4; k++) step(0, '0, 1, 2'(k), 0, 0, "R3 access order");
      step(0, '0, 0, 0, 0, 0, "R3 after order");
      check(itlb_victim == 2'd0, "R3 oldest after sweep", 32'(itlb_victim), 32'd0);
      // R3: repeat one entry
      for (int k = 0; k < 3; k++) step(0, '0, 1, 2'd2, 0, 0, "R3 repeat access");

      // R5: cyclic age field
      step(1, 32'hBC00_0000, 0, 0, 0, 0, "R2 write");
      step(0, '0, 0, 0, 0, 0, "R5 illegal hold");
      check(itlb_lru_err && itlb_victim == 2'd0, "R5 illegal decode",
            {29'd0, itlb_lru_err, itlb_victim}, 32'h4);
      step(0, '0, 1, 2'd1, 0, 0, "R3 access from illegal");

      // R6: boundary 5 from 0
      step(1, (32'd5 << 18), 0, 0, 0, 0, "R2 write");
      for (int i = 0; i < 9; i++) step(0, '0, 0, 0, 1, i[0], "R6 bounded wrap");
      // R6: start above boundary
      step(1, (32'd3 << 18) | (32'd10 << 10), 0, 0, 0, 0, "R2 write");
      step(0, '0, 0, 0, 1, 1, "R6 above boundary");
      step(0, '0, 0, 0, 0, 0, "R6 above boundary result");
      check(ctl_q[15:10] == 6'd0, "R6 wrap from above", 32'(ctl_q[15:10]), 32'd0);
      // R7: boundary 0 across 63
      step(1, (32'd62 << 10), 0, 0, 0, 0, "R2 write");
      for (int i = 0; i < 4; i++) step(0, '0, 0, 0, 1, 1, "R7 full wrap");
      // R8: load with tick in same cycle, uses pre-tick value
      step(0, '0, 0, 0, 1, 1, "R8 load and tick");
      // R2: write wins over access and tick in same cycle
      step(1, 32'h0301_3C05, 1, 2'd3, 1, 0, "R2 write priority");
      step(0, '0, 0, 0, 0, 0, "R2 write priority result");
      // R9: misc bits kept through activity
      step(1, 32'h03C3_03FF | (32'd4 << 18), 0, 0, 0, 0, "R2 write");
      for (int i = 0; i < 12; i++) step(0, '0, 1, 2'(i), 1, 0, "R9 misc hold");

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] d;
         logic        wr;
         wr = ($urandom % 16) == 0;
         d  = $urandom;
         if ($urandom % 2) d[23:18] = 6'($urandom % 8);
         step(wr, d, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
              wr ? "R2 random" : "R9 random");
      end
      step(0, '0, 0, 0, 0, 0, "R9 final");

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule